// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts the direction of a conditional branch by running two direction predictors side by side and letting a per-branch chooser decide which one to trust. The first component is a table of 2-bit saturating counters addressed only by the branch address. Such a counter follows the usual direction of a branch, so a strongly biased branch costs one miss for each rare outcome. The second component is a table of 2-bit counters addressed by the branch address XORed with a global history of recent resolved outcomes, which lets it learn repeating patterns. A third table of 2-bit counters, addressed by the branch address, selects the component whose answer is driven out.

The lookup is combinational: the fetch stage presents a PC and gets the final direction back in the same cycle, together with both component answers, the chooser decision and the history value used. The fetch stage keeps these with the branch. When the branch resolves, it returns the PC, the real outcome, both component answers and the saved history snapshot. Both components are then trained toward the outcome, the chooser moves toward the component that was right, and the outcome is shifted into the global history. Updates take effect at the clock edge, so a lookup in the same cycle as an update still sees the older state.

Top module: `tourney_bp`

## Requirements
- R1: After reset every counter in all three tables holds 01 and the global history is all zeros, so every lookup returns not-taken from both components with the address-only component selected.
- R2: The address-only component reads the counter at PC bits [2 +: BIM_IDX_W] and predicts taken when that counter's upper bit is 1 (values 10 and 11).
- R3: The history component reads the counter at PC bits [2 +: GSH_IDX_W] XOR the global history (zero-extended, or cut to its low GSH_IDX_W bits) and predicts taken when that counter's upper bit is 1.
- R4: The chooser counter at PC bits [2 +: SEL_IDX_W] selects the history component when its value is 10 or 11 and the address-only component when it is 00 or 01; the final prediction equals the selected component's answer.
- R5: All counters saturate: an increment at 11 leaves 11 and a decrement at 00 leaves 00, so one rare outcome after a run of the usual one does not flip a strongly trained prediction.
- R6: Each valid update trains both components toward the outcome (increment when taken, decrement when not), whichever one was selected; the history component is addressed by the returned history snapshot, not the current history.
- R7: The chooser entry changes only when the returned component answers differ: it increments when the history component's answer matched the outcome and decrements when the address-only component's answer did.
- R8: On each valid update the history shifts left by one and the outcome enters at bit 0 (1 = taken); the current history is presented at the lookup port.
- R9: With the update valid low, no table entry and no history bit changes, whatever the other update inputs carry.
- R10: A lookup in the same cycle as an update returns the state before that update; the new state is visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lkp_pc_i | input | PC_W | Branch address being looked up |
| pred_taken_o | output | 1 | Final predicted direction (1 = taken) |
| pred_bim_o | output | 1 | Address-only component answer |
| pred_gsh_o | output | 1 | History component answer |
| pred_use_glob_o | output | 1 | 1 when the history component was selected |
| pred_hist_o | output | HIST_W | Global history used for this lookup |
| upd_valid_i | input | 1 | Resolved branch update strobe |
| upd_pc_i | input | PC_W | Address of the resolved branch |
| upd_taken_i | input | 1 | Real outcome (1 = taken) |
| upd_bim_i | input | 1 | Address-only answer saved at lookup |
| upd_gsh_i | input | 1 | History answer saved at lookup |
| upd_hist_i | input | HIST_W | History snapshot saved at lookup |

## Verification
The bench builds the predictor with an 8-entry address-only table, a 16-entry history table, a 4-entry chooser and a 3-bit history, so the history is narrower than the history-table index and gets zero-extended. With tables this small, aliasing between branches whose addresses share low bits, saturation at both counter ends and chooser swings all happen within a few dozen updates. The reduced chooser depth also makes distinct branches share chooser entries, which probes that the chooser is addressed independently of the component tables.

// File: rtl/tourney_bp_pkg.sv
package tourney_bp_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_INIT = 2'b01;

  function automatic ctr_t ctr_step(ctr_t c, logic up);
    if (up) return (c == 2'b11) ? c : c + 2'b01;
    else    return (c == 2'b00) ? c : c - 2'b01;
  endfunction

  function automatic logic ctr_dir(ctr_t c);
    return c[1];
  endfunction

endpackage

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
  import tourney_bp_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_dir_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_up_i
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t ctr_vec [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    ctr_t q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        q <= CTR_INIT;
      else if (wr_en_i && (wr_idx_i == IDX_W'(g)))
        q <= ctr_step(q, wr_up_i);
    end
    assign ctr_vec[g] = q;
  end

  assign rd_dir_o = ctr_dir(ctr_vec[rd_idx_i]);

endmodule

// File: rtl/bp_hist_reg.sv
module bp_hist_reg #(
  parameter int HIST_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_q <= '0;
    else if (shift_i) hist_q <= {hist_q[HIST_W-2:0], bit_i};
  end

  assign hist_o = hist_q;

endmodule

// File: rtl/bp_gidx.sv
module bp_gidx #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 6,
  parameter int HIST_W = 6
) (
  input  logic [PC_W-1:0]   pc_i,
  input  logic [HIST_W-1:0] hist_i,
  output logic [IDX_W-1:0]  idx_o
);
  logic [IDX_W-1:0] hist_fit;

  if (HIST_W >= IDX_W) begin : g_cut
    assign hist_fit = hist_i[IDX_W-1:0];
  end else begin : g_ext
    assign hist_fit = {{(IDX_W-HIST_W){1'b0}}, hist_i};
  end

  assign idx_o = pc_i[2 +: IDX_W] ^ hist_fit;

endmodule

// File: rtl/tourney_bp.sv
module tourney_bp #(
  parameter int PC_W      = 32,
  parameter int BIM_IDX_W = 6,
  parameter int GSH_IDX_W = 6,
  parameter int SEL_IDX_W = 6,
  parameter int HIST_W    = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PC_W-1:0]   lkp_pc_i,
  output logic              pred_taken_o,
  output logic              pred_bim_o,
  output logic              pred_gsh_o,
  output logic              pred_use_glob_o,
  output logic [HIST_W-1:0] pred_hist_o,
  input  logic              upd_valid_i,
  input  logic [PC_W-1:0]   upd_pc_i,
  input  logic              upd_taken_i,
  input  logic              upd_bim_i,
  input  logic              upd_gsh_i,
  input  logic [HIST_W-1:0] upd_hist_i
);
  logic [HIST_W-1:0]    hist;
  logic [GSH_IDX_W-1:0] g_rd_idx, g_wr_idx;
  logic                 sel_wr_en, sel_up;

  bp_hist_reg #(.HIST_W(HIST_W)) u_hist (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(upd_valid_i),
    .bit_i  (upd_taken_i),
    .hist_o (hist)
  );

  bp_gidx #(.PC_W(PC_W), .IDX_W(GSH_IDX_W), .HIST_W(HIST_W)) u_gidx_rd (
    .pc_i  (lkp_pc_i),
    .hist_i(hist),
    .idx_o (g_rd_idx)
  );

  bp_gidx #(.PC_W(PC_W), .IDX_W(GSH_IDX_W), .HIST_W(HIST_W)) u_gidx_wr (
    .pc_i  (upd_pc_i),
    .hist_i(upd_hist_i),
    .idx_o (g_wr_idx)
  );

  bp_ctr_table #(.IDX_W(BIM_IDX_W)) u_bim (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_idx_i(lkp_pc_i[2 +: BIM_IDX_W]),
    .rd_dir_o(pred_bim_o),
    .wr_en_i (upd_valid_i),
    .wr_idx_i(upd_pc_i[2 +: BIM_IDX_W]),
    .wr_up_i (upd_taken_i)
  );

  bp_ctr_table #(.IDX_W(GSH_IDX_W)) u_gsh (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_idx_i(g_rd_idx),
    .rd_dir_o(pred_gsh_o),
    .wr_en_i (upd_valid_i),
    .wr_idx_i(g_wr_idx),
    .wr_up_i (upd_taken_i)
  );

  // chooser trains only on disagreement; up = history side was right
  assign sel_wr_en = upd_valid_i && (upd_bim_i != upd_gsh_i);
  assign sel_up    = (upd_gsh_i == upd_taken_i);

  bp_ctr_table #(.IDX_W(SEL_IDX_W)) u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_idx_i(lkp_pc_i[2 +: SEL_IDX_W]),
    .rd_dir_o(pred_use_glob_o),
    .wr_en_i (sel_wr_en),
    .wr_idx_i(upd_pc_i[2 +: SEL_IDX_W]),
    .wr_up_i (sel_up)
  );

  assign pred_taken_o = pred_use_glob_o ? pred_gsh_o : pred_bim_o;
  assign pred_hist_o  = hist;

endmodule

// File: rtl/tourney_bp_chk.sv
module tourney_bp_chk #(
  parameter int PC_W   = 32,
  parameter int HIST_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [PC_W-1:0]   lkp_pc_i,
  input logic              pred_taken_o,
  input logic              pred_bim_o,
  input logic              pred_gsh_o,
  input logic              pred_use_glob_o,
  input logic [HIST_W-1:0] pred_hist_o,
  input logic              upd_valid_i,
  input logic [PC_W-1:0]   upd_pc_i,
  input logic              upd_taken_i,
  input logic              upd_bim_i,
  input logic              upd_gsh_i
);

  assert_sel_mux_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_taken_o == (pred_use_glob_o ? pred_gsh_o : pred_bim_o));

  assert_hist_in_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> pred_hist_o[0] == $past(upd_taken_i));

  assert_hist_shift_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> pred_hist_o[HIST_W-1:1] == $past(pred_hist_o[HIST_W-2:0]));

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> ($stable(pred_hist_o) &&
                      (!$stable(lkp_pc_i) || $stable(pred_taken_o))));

  assert_sel_agree_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && (upd_bim_i == upd_gsh_i)) |=>
      (!$stable(lkp_pc_i) || $stable(pred_use_glob_o)));

  assert_bim_train_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_taken_i && (upd_pc_i == lkp_pc_i) && pred_bim_o) |=>
      (!$stable(lkp_pc_i) || pred_bim_o));

endmodule

bind tourney_bp tourney_bp_chk #(.PC_W(PC_W), .HIST_W(HIST_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .lkp_pc_i       (lkp_pc_i),
  .pred_taken_o   (pred_taken_o),
  .pred_bim_o     (pred_bim_o),
  .pred_gsh_o     (pred_gsh_o),
  .pred_use_glob_o(pred_use_glob_o),
  .pred_hist_o    (pred_hist_o),
  .upd_valid_i    (upd_valid_i),
  .upd_pc_i       (upd_pc_i),
  .upd_taken_i    (upd_taken_i),
  .upd_bim_i      (upd_bim_i),
  .upd_gsh_i      (upd_gsh_i)
);

// File: tb/tourney_bp_test.sv
`timescale 1ns/1ps
module tourney_bp_test;
  localparam int PC_W = 32, BW = 3, GW = 4, SW = 2, HW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [PC_W-1:0] lkp_pc = '0, upd_pc = '0;
  logic          upd_valid = 1'b0, upd_taken = 1'b0, upd_bim = 1'b0, upd_gsh = 1'b0;
  logic [HW-1:0] upd_hist = '0;
  logic          p_taken, p_bim, p_gsh, p_glob;
  logic [HW-1:0] p_hist;

  int checks = 0, errors = 0;
  bit done = 0;

  int m_bim [1<<BW];
  int m_gsh [1<<GW];
  int m_sel [1<<SW];
  int m_hist;

  always #10 clk = ~clk;

  tourney_bp #(.PC_W(PC_W), .BIM_IDX_W(BW), .GSH_IDX_W(GW),
               .SEL_IDX_W(SW), .HIST_W(HW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .lkp_pc_i(lkp_pc),
    .pred_taken_o(p_taken), .pred_bim_o(p_bim), .pred_gsh_o(p_gsh),
    .pred_use_glob_o(p_glob), .pred_hist_o(p_hist),
    .upd_valid_i(upd_valid), .upd_pc_i(upd_pc), .upd_taken_i(upd_taken),
    .upd_bim_i(upd_bim), .upd_gsh_i(upd_gsh), .upd_hist_i(upd_hist)
  );

  function automatic int sat(int c, bit up);
    if (up) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    foreach (m_bim[i]) m_bim[i] = 1;
    foreach (m_gsh[i]) m_gsh[i] = 1;
    foreach (m_sel[i]) m_sel[i] = 1;
    m_hist = 0;
  endtask

  // drive one cycle, compare against the model's pre-edge state, then advance the model
  task automatic step(string tag, int lpc, bit uv, int upc, bit ut, bit ub, bit ug, int uh);
    int bi, gi, si, eb, eg, es;
    @(negedge clk);
    lkp_pc = PC_W'(lpc); upd_valid = uv; upd_pc = PC_W'(upc);
    upd_taken = ut; upd_bim = ub; upd_gsh = ug; upd_hist = HW'(uh);
    #2;
    bi = (lpc >> 2) & ((1 << BW) - 1);
    gi = ((lpc >> 2) & ((1 << GW) - 1)) ^ m_hist;
    si = (lpc >> 2) & ((1 << SW) - 1);
    eb = (m_bim[bi] >= 2); eg = (m_gsh[gi] >= 2); es = (m_sel[si] >= 2);
    chk({tag, "/R2"}, "bim", int'(p_bim), eb);
    chk({tag, "/R3"}, "gsh", int'(p_gsh), eg);
    chk({tag, "/R4"}, "sel", int'(p_glob), es);
    chk({tag, "/R4"}, "taken", int'(p_taken), es ? eg : eb);
    chk({tag, "/R8"}, "hist", int'(p_hist), m_hist);
    @(posedge clk);
    if (uv) begin
      bi = (upc >> 2) & ((1 << BW) - 1);
      gi = ((upc >> 2) & ((1 << GW) - 1)) ^ (uh & ((1 << HW) - 1));
      si = (upc >> 2) & ((1 << SW) - 1);
      m_bim[bi] = sat(m_bim[bi], ut);
      m_gsh[gi] = sat(m_gsh[gi], ut);
      if (ub != ug) m_sel[si] = sat(m_sel[si], ug == ut);
      m_hist = ((m_hist << 1) | int'(ut)) & ((1 << HW) - 1);
    end
  endtask

  task automatic upd(string tag, int pc, bit t, bit b, bit g, int h);
    step(tag, pc, 1, pc, t, b, g, h);
  endtask

  task automatic look(string tag, int pc);
    step(tag, pc, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state
    #2;
    chk("R1", "taken", int'(p_taken), 0);
    chk("R1", "use_glob", int'(p_glob), 0);
    chk("R1", "hist", int'(p_hist), 0);
    for (int a = 0; a < 16; a++) look("R1", a * 4);

    // R5: saturation high, then one rare outcome keeps taken
    for (int k = 0; k < 5; k++) upd("R5", 'h10, 1, 0, 0, 0);
    upd("R5", 'h10, 0, 1, 1, 0);
    look("R5", 'h10);
    chk("R5", "bim_after_rare", int'(p_bim), 1);
    for (int k = 0; k < 6; k++) upd("R5", 'h10, 0, 0, 0, 0);
    upd("R5", 'h10, 1, 0, 0, 0);
    look("R5", 'h10);
    chk("R5", "bim_low_sat", int'(p_bim), 0);

    // R6: history snapshot addresses the global table, not current history
    upd("R6", 'h24, 1, 0, 0, 5);
    upd("R6", 'h24, 1, 0, 0, 5);
    for (int k = 0; k < 4; k++) look("R6", 'h24 + k * 64);

    // R7: chooser moves only on disagreement
    upd("R7", 'h8, 1, 1, 1, 0);
    look("R7", 'h8);
    chk("R7", "agree_no_move", int'(p_glob), 0);
    upd("R7", 'h8, 1, 0, 1, 0);
    look("R7", 'h8);
    chk("R7", "glob_right", int'(p_glob), 1);
    upd("R7", 'h8, 0, 0, 1, 0);
    upd("R7", 'h8, 0, 0, 1, 0);
    look("R7", 'h8);
    chk("R7", "bim_right", int'(p_glob), 0);

    // R9: invalid update with busy payload changes nothing
    for (int k = 0; k < 8; k++) step("R9", 'h8, 0, 'h8, 1, 0, 1, k);
    look("R9", 'h8);
    chk("R9", "sel_hold", int'(p_glob), 0);

    // R10: lookup of the entry being written sees old value
    for (int k = 0; k < 3; k++) step("R10", 'h30, 1, 'h30, 1, 1, 0, 0);
    look("R10", 'h30);

    // R8 and mixed traffic: loop pattern then random traffic
    for (int k = 0; k < 40; k++) begin
      int pc = 'h40;
      look("R8", pc);
      upd("R8", pc, (k % 4) != 3, p_bim, p_gsh, int'(p_hist));
    end
    for (int k = 0; k < 1500; k++) begin
      int pc = int'($urandom_range(0, 31)) * 4;
      step("RND", int'($urandom_range(0, 31)) * 4, $urandom_range(0, 3) != 0,
           pc, 1'($urandom), 1'($urandom), 1'($urandom), int'($urandom_range(0, 7)));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule